// File: doc/BRIEF.md
# Snooped Bank Window Mapper

This block sits beside an 8-bit processor and watches its bus. The processor treats three spare opcodes, 0x42, 0xC2 and 0xE2, as two-byte, two-cycle no-operations: it fetches the operand byte and then discards it. The block spots each of these opcodes during an opcode fetch and keeps the operand byte that follows. That byte becomes the bank number of one of three memory windows. Software can therefore change a window with a single instruction whose operand is the bank number. The instruction uses no processor register and needs no store.

The 64 KB logical space is divided into four 16 KB slots. Slots 1, 2 and 3 are windows 0, 1 and 2. In those slots the block replaces the top two address bits with the bank register of that window, which gives a wider physical address. With the default width this is 32 banks of 16 KB, or 512 KB in total. Slot 0 passes through unchanged. Each window register also has its own I/O address, so a bank number computed at run time can be stored there with an ordinary write.

Top module: `bus_window_mapper`

## Requirements
- R1: After reset, all three bank registers read zero. A window access then maps to bank 0: `phys_addr` = {0, addr[13:0]}.
- R2: Opcode 0x42, 0xC2 or 0xE2 on `data` in a valid cycle with `sync` high arms window 0, 1 or 2 respectively. The next valid cycle is the operand cycle, and in it `data[BANK_W-1:0]` is loaded into that window's register. The new value is visible from the clock edge that ends the operand cycle.
- R3: A cycle with `sync` low never arms a window, even when `data` holds one of the three opcodes. A cycle with `sync` high and any other byte does not arm a window either.
- R4: Cycles with `cyc_valid` low are ignored. They neither arm a window nor act as an operand cycle, and an armed window stays armed across them.
- R5: A valid write cycle (`rw`=0) to address 0x0200+k, for k = 0, 1, 2, loads `data[BANK_W-1:0]` into window k's register.
- R6: In an operand cycle the snooped load wins. Any I/O write in the same cycle is dropped for every window.
- R7: When addr[15:14] = k+1, `win_hit` is 1 and `phys_addr` = {bank register k, addr[13:0]}.
- R8: When addr[15:14] = 0, `win_hit` is 0 and `phys_addr` is `addr` zero-extended.
- R9: Loading one window, by either path, leaves the other two registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; inputs are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_valid | input | 1 | High in a clock cycle that carries a completed bus cycle |
| sync | input | 1 | High during an opcode fetch |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 16 | Logical address bus |
| data | input | 8 | Data bus |
| phys_addr | output | 14+BANK_W | Translated physical address |
| win_hit | output | 1 | High when addr falls in one of the three window slots |

## Verification
The address translation is combinational. The bench therefore compares `phys_addr` and `win_hit` in the same cycle the address is driven, sampled 5 ns after the falling edge, against a model that holds the bank values already committed. A bank change takes effect at the rising edge that ends the operand or I/O cycle: two edges after the opcode fetch when no idle cycles come between. The bench updates its model only after that edge, so the earliest probe that can see the new bank is the next cycle. Directed sequences insert idle cycles and collisions between trigger and operand, and then probe every window.

// File: rtl/wsel_pkg.sv
package wsel_pkg;
    localparam int NWIN  = 3;
    localparam int OFS_W = 14;
    localparam int LOG_W = 16;

    function automatic logic [7:0] trig_opcode(input int k);
        case (k)
            0:       return 8'h42;
            1:       return 8'hC2;
            default: return 8'hE2;
        endcase
    endfunction

    function automatic logic [LOG_W-OFS_W-1:0] win_slot(input int k);
        return (LOG_W-OFS_W)'(k + 1);
    endfunction
endpackage

// File: rtl/opcode_snoop.sv
module opcode_snoop
    import wsel_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cyc_valid,
    input  logic            sync,
    input  logic [7:0]      data,
    output logic [NWIN-1:0] pend
);
    typedef struct packed {
        logic [NWIN-1:0] pend;
    } snoop_t;

    snoop_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cyc_valid) begin
            st_d.pend = '0;
            if (sync) begin
                for (int k = 0; k < NWIN; k++) begin
                    if (data == trig_opcode(k)) st_d.pend[k] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;

    AST_NO_SYNC_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && !sync) |=> (pend == '0)); // R3
    AST_ARM_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_valid |=> $stable(pend)); // R4
    AST_ONE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pend)); // R2
endmodule

// File: rtl/window_regs.sv
module window_regs
    import wsel_pkg::*;
#(
    parameter int              BANK_W  = 5,
    parameter logic [LOG_W-1:0] IO_BASE = 16'h0200
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cyc_valid,
    input  logic                         rw,
    input  logic [LOG_W-1:0]             addr,
    input  logic [7:0]                   data,
    input  logic [NWIN-1:0]              pend,
    output logic [NWIN-1:0][BANK_W-1:0]  win
);
    typedef struct packed {
        logic [NWIN-1:0][BANK_W-1:0] win;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cyc_valid) begin
            for (int k = 0; k < NWIN; k++) begin
                if (|pend) begin
                    if (pend[k]) st_d.win[k] = data[BANK_W-1:0];
                end else if (!rw && addr == LOG_W'(IO_BASE + LOG_W'(k))) begin
                    st_d.win[k] = data[BANK_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign win = st_q.win;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_valid |=> $stable(win)); // R4

    for (genvar g = 0; g < NWIN; g++) begin : g_chk
        AST_SNOOP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (cyc_valid && pend[g]) |=> (win[g] == $past(data[BANK_W-1:0]))); // R2
        AST_IO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (cyc_valid && !rw && pend == '0 && addr == LOG_W'(IO_BASE + LOG_W'(g)))
            |=> (win[g] == $past(data[BANK_W-1:0]))); // R5
        AST_SNOOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (cyc_valid && (|pend) && !pend[g]) |=> $stable(win[g])); // R6
    end
endmodule

// File: rtl/addr_map.sv
module addr_map
    import wsel_pkg::*;
#(
    parameter int BANK_W = 5,
    localparam int PHYS_W = OFS_W + BANK_W
) (
    input  logic [LOG_W-1:0]             addr,
    input  logic [NWIN-1:0][BANK_W-1:0]  win,
    output logic [PHYS_W-1:0]            phys_addr,
    output logic                         win_hit
);
    logic [NWIN-1:0] slot_hit;

    for (genvar g = 0; g < NWIN; g++) begin : g_dec
        assign slot_hit[g] = (addr[LOG_W-1:OFS_W] == win_slot(g));
    end

    always_comb begin
        phys_addr = PHYS_W'(addr);
        for (int k = 0; k < NWIN; k++) begin
            if (slot_hit[k]) phys_addr = {win[k], addr[OFS_W-1:0]};
        end
        win_hit = |slot_hit;
    end
endmodule

// File: rtl/bus_window_mapper.sv
module bus_window_mapper
    import wsel_pkg::*;
#(
    parameter int               BANK_W  = 5,
    parameter logic [15:0]      IO_BASE = 16'h0200,
    localparam int              PHYS_W  = OFS_W + BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_valid,
    input  logic              sync,
    input  logic              rw,
    input  logic [15:0]       addr,
    input  logic [7:0]        data,
    output logic [PHYS_W-1:0] phys_addr,
    output logic              win_hit
);
    logic [NWIN-1:0]             pend;
    logic [NWIN-1:0][BANK_W-1:0] win;

    opcode_snoop u_snoop (
        .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid),
        .sync(sync), .data(data), .pend(pend)
    );

    window_regs #(.BANK_W(BANK_W), .IO_BASE(IO_BASE)) u_regs (
        .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .rw(rw),
        .addr(addr), .data(data), .pend(pend), .win(win)
    );

    addr_map #(.BANK_W(BANK_W)) u_map (
        .addr(addr), .win(win), .phys_addr(phys_addr), .win_hit(win_hit)
    );

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[15:14] == 2'd0) |-> (!win_hit && phys_addr == PHYS_W'(addr))); // R8
    AST_WIN1_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[15:14] == 2'd2) |-> (win_hit && phys_addr == {win[1], addr[13:0]})); // R7
endmodule

// File: tb/sim_bus_window_mapper.sv
module sim_bus_window_mapper;
    localparam int BANK_W = 5;
    localparam int PHYS_W = 14 + BANK_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_valid = 1'b0, sync = 1'b0, rw = 1'b1;
    logic [15:0] addr = '0;
    logic [7:0]  data = '0;
    logic [PHYS_W-1:0] phys_addr;
    logic win_hit;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    logic [BANK_W-1:0] mwin [3];
    int mpend = -1;

    always #10 clk = ~clk;

    bus_window_mapper #(.BANK_W(BANK_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .sync(sync), .rw(rw),
        .addr(addr), .data(data), .phys_addr(phys_addr), .win_hit(win_hit)
    );

    function automatic int opc_idx(input logic [7:0] d);
        case (d)
            8'h42:   return 0;
            8'hC2:   return 1;
            8'hE2:   return 2;
            default: return -1;
        endcase
    endfunction

    function automatic logic [PHYS_W-1:0] exp_phys(input logic [15:0] a);
        if (a[15:14] == 2'd0) return PHYS_W'(a);
        return {mwin[a[15:14]-1], a[13:0]};
    endfunction

    task automatic compare(input string req, input logic [15:0] a);
        logic [PHYS_W-1:0] ep = exp_phys(a);
        logic eh = (a[15:14] != 2'd0);
        checks++;
        if (phys_addr !== ep || win_hit !== eh) begin
            fails++;
            $display("FAIL %s addr=%h: phys=%h hit=%b expected phys=%h hit=%b",
                     req, a, phys_addr, win_hit, ep, eh);
        end
    endtask

    // one clock: drive, optionally compare, then update model after the edge
    task automatic step(input logic v, input logic s, input logic r,
                        input logic [15:0] a, input logic [7:0] d, input bit chk);
        @(negedge clk);
        cyc_valid = v; sync = s; rw = r; addr = a; data = d;
        #5;
        if (chk) compare(a[15:14] == 2'd0 ? "R8" : "R7", a);
        @(posedge clk);
        if (v) begin
            if (mpend >= 0) mwin[mpend] = d[BANK_W-1:0];
            else if (!r && a >= 16'h0200 && a <= 16'h0202) mwin[a - 16'h0200] = d[BANK_W-1:0];
            mpend = s ? opc_idx(d) : -1;
        end
    endtask

    task automatic probe(input string req, input logic [15:0] a);
        @(negedge clk);
        cyc_valid = 1'b0; sync = 1'b0; rw = 1'b1; addr = a;
        #5;
        compare(req, a);
    endtask

    task automatic expect_bank(input string req, input int k, input logic [BANK_W-1:0] v);
        checks++;
        if (mwin[k] !== v) begin
            fails++;
            $display("FAIL %s model bank%0d=%h expected %h", req, k, mwin[k], v);
        end
        probe(req, 16'(((k + 1) << 14) | 16'h0155));
    endtask

    initial begin
        mwin[0] = '0; mwin[1] = '0; mwin[2] = '0;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        probe("R1", 16'h4abc); probe("R1", 16'h8001); probe("R1", 16'hfff0);
        probe("R8", 16'h1234);

        // R2: each opcode loads its own window
        step(1, 1, 1, 16'h1000, 8'h42, 0); step(1, 0, 1, 16'h1001, 8'h15, 0);
        expect_bank("R2", 0, 5'h15);
        step(1, 1, 1, 16'h1002, 8'hC2, 0); step(1, 0, 1, 16'h1003, 8'h0a, 0);
        expect_bank("R2", 1, 5'h0a);
        step(1, 1, 1, 16'h1004, 8'hE2, 0); step(1, 0, 1, 16'h1005, 8'h1f, 0);
        expect_bank("R2", 2, 5'h1f);
        // R9: others unchanged
        expect_bank("R9", 0, 5'h15); expect_bank("R9", 1, 5'h0a);

        // R3: opcode byte without sync, and non-opcode with sync
        step(1, 0, 1, 16'h1006, 8'h42, 0); step(1, 0, 1, 16'h1007, 8'h03, 0);
        expect_bank("R3", 0, 5'h15);
        step(1, 1, 1, 16'h1008, 8'h43, 0); step(1, 0, 1, 16'h1009, 8'h04, 0);
        expect_bank("R3", 0, 5'h15);

        // R4: idle cycles between trigger and operand
        step(1, 1, 1, 16'h100a, 8'hC2, 0);
        step(0, 1, 1, 16'h100b, 8'h42, 0); step(0, 0, 1, 16'h100b, 8'h11, 0);
        expect_bank("R4", 1, 5'h0a);
        step(1, 0, 1, 16'h100b, 8'h07, 0);
        expect_bank("R4", 1, 5'h07);
        expect_bank("R4", 0, 5'h15);

        // R5: I/O writes
        step(1, 0, 0, 16'h0200, 8'h02, 0); expect_bank("R5", 0, 5'h02);
        step(1, 0, 0, 16'h0202, 8'h19, 0); expect_bank("R5", 2, 5'h19);
        expect_bank("R9", 1, 5'h07);

        // R6: collision, snoop wins, I/O write to other window dropped
        step(1, 1, 1, 16'h100c, 8'h42, 0); step(1, 0, 0, 16'h0200, 8'h0c, 0);
        expect_bank("R6", 0, 5'h0c);
        step(1, 1, 1, 16'h100d, 8'hE2, 0); step(1, 0, 0, 16'h0201, 8'h0d, 0);
        expect_bank("R6", 1, 5'h07); expect_bank("R6", 2, 5'h0d);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic v = ($urandom % 4) != 0;
            logic s = ($urandom % 2) != 0;
            logic r = ($urandom % 3) != 0;
            logic [15:0] a = 16'($urandom);
            logic [7:0] d = 8'($urandom);
            if ($urandom % 3 == 0) d = ($urandom % 3 == 0) ? 8'h42 : (($urandom % 2) ? 8'hC2 : 8'hE2);
            if (!r && $urandom % 2 == 0) a = 16'h0200 + 16'($urandom % 3);
            step(v, s, r, a, d, 1);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule